// File: doc/BRIEF.md
# Bang-Bang Proportional-Integral Loop Filter

This block is the digital controller of an integer-N bang-bang PLL. It runs on the retimed feedback clock. On each edge it receives one held early/late decision and turns it into an 8-bit oscillator tuning code. It also produces a 255-line thermometer decode of that code, which drives the oscillator's load bank. The internal control word is 10 bits wide. The code is its upper eight bits. The integrator carries eight more fractional bits underneath, so an integral gain can be set finer than one code step.

A proportional correction is added on the same edge as the decision. The integral state moves only on qualified updates and saturates at its limits. Three aids help the loop leave the code rails during acquisition:
- a decision that would push further past a rail is inverted;
- an optional streak boost enlarges the integral step after several same-direction decisions;
- an optional forced-inward zone drives the integrator toward mid-range near either rail.

Software-style controls select the modes: enable, clear/reload, external override, polarity and gains. The decision is a level, not a stream. It is sampled on every edge, so there is no handshake and no back-pressure.

Top module: `bbpi_loop_filter`

## Requirements
- R1: An active-low reset sets the code to 0, the thermometer to its code-0 pattern, and the integrator and streak state to zero.
- R2: Each accepted update adds or subtracts the integral gain in units of 2^-8 of a word LSB. One code step is therefore 1024 integral units.
- R3: Decision encoding: 2'b10 means raise frequency and 2'b01 means lower it; 2'b00 and 2'b11 are idle. While enabled, the proportional gain, in word LSBs, is added or subtracted on the same edge. The code is word bits [9:2], so a gain of 4 moves the code by one step.
- R4: At code 0 a lowering decision, and at code 255 a raising decision, is turned inward for both the proportional and the integral paths.
- R5: With BOOST_SHIFT nonzero, an update in the same direction as the previous BOOST_AFTER or more consecutive integral updates uses the gain shifted left by BOOST_SHIFT. An idle update or a change of direction restarts the streak.
- R6: With FORCE_RAIL nonzero, integral updates are forced upward while the code is below FORCE_RAIL, and forced downward while it is above 255-FORCE_RAIL.
- R7: With enable low (and no clear or override), code and thermometer hold. Clear loads the integrator with external data (zero fraction), clears the streak, and drives the code from external data [9:2].
- R8: Override drives the code from external data [9:2] and leaves the integrator and streak untouched.
- R9: Polarity high uses the decision as given; polarity low reverses its direction.
- R10: Thermometer line i is high when the code is at most i, so code 0 sets all 255 lines and code 255 sets none. It is registered on the same edge as the code.
- R11: The integrator and the proportional sum saturate at 0 and at full scale instead of wrapping.
- R12: The integral state and the streak advance only when the update qualifier is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retimed feedback clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Loop enable; low freezes the outputs |
| clr_i | input | 1 | Synchronous clear/reload from ext_i |
| ovr_i | input | 1 | External override of the output code |
| upd_i | input | 1 | Integral update qualifier |
| pol_i | input | 1 | Decision polarity select |
| dec_i | input | 2 | Held early/late decision |
| ext_i | input | 10 | External control word |
| ki_i | input | 8 | Integral gain |
| kp_i | input | 6 | Proportional gain |
| code_o | output | 8 | Registered oscillator code |
| therm_o | output | 255 | Registered thermometer decode |

## Verification
The bench tests a configuration with the boost and the forced rail zone enabled. The first stimulus is an override sweep over all 256 codes, which separates a correct thermometer from an off-by-one or wrong-polarity decode.

Directed sequences start from known reloads:
- a word sitting just below a code boundary tells a correct fraction width from a wrong one;
- four same-direction updates from mid-range tell a boosted step from a plain one;
- loads at the rails and near them expose a missing escape, a missing forced zone or a wrapping clamp.

A long pseudo-random run then mixes every mode and gain against an arithmetic model. This catches priority errors between clear, override, enable and the qualifier.

// File: rtl/bbpi_pkg.sv
package bbpi_pkg;

  // Signed direction: +1 raise frequency, -1 lower it, 0 idle.
  typedef logic signed [1:0] dir_t;

  localparam dir_t DIR_UP   = 2'sb01;
  localparam dir_t DIR_DN   = 2'sb11;
  localparam dir_t DIR_NONE = 2'sb00;

  function automatic dir_t decode_dir(input logic [1:0] dec);
    case (dec)
      2'b10:   return DIR_UP;
      2'b01:   return DIR_DN;
      default: return DIR_NONE;
    endcase
  endfunction

  function automatic dir_t flip_dir(input dir_t d);
    case (d)
      DIR_UP:  return DIR_DN;
      DIR_DN:  return DIR_UP;
      default: return DIR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bbpi_decision.sv
module bbpi_decision
  import bbpi_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int BOOST_AFTER = 4,
  parameter int FORCE_RAIL  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              flush,
  input  logic              pol,
  input  logic [1:0]        dec,
  input  logic [CODE_W-1:0] code,
  output dir_t              dir_p,
  output dir_t              dir_i,
  output logic              boost
);

  localparam int CNT_W = $clog2(BOOST_AFTER + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_LIM  = CNT_W'(BOOST_AFTER);

  dir_t raw, eff;
  logic at_lo, at_hi;

  always_comb begin
    raw   = decode_dir(dec);
    eff   = pol ? raw : flip_dir(raw);
    at_lo = (code == '0);
    at_hi = (code == CODE_MAX);
    dir_p = eff;
    if (at_lo && eff == DIR_DN)      dir_p = DIR_UP;   // R4 escape low rail
    else if (at_hi && eff == DIR_UP) dir_p = DIR_DN;   // R4 escape high rail
  end

  generate
    if (FORCE_RAIL > 0) begin : g_force
      localparam logic [CODE_W-1:0] LO_LIM = CODE_W'(FORCE_RAIL);
      localparam logic [CODE_W-1:0] HI_LIM = CODE_MAX - LO_LIM;
      always_comb begin
        if (code < LO_LIM)      dir_i = DIR_UP;
        else if (code > HI_LIM) dir_i = DIR_DN;
        else                    dir_i = dir_p;
      end
    end else begin : g_noforce
      assign dir_i = dir_p;
    end
  endgenerate

  logic [CNT_W-1:0] streak_q;
  dir_t             last_q;

  assign boost = (dir_i != DIR_NONE) && (dir_i == last_q) && (streak_q >= CNT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
      last_q   <= DIR_NONE;
    end else if (flush) begin
      streak_q <= '0;
      last_q   <= DIR_NONE;
    end else if (adv) begin
      if (dir_i == DIR_NONE) begin
        streak_q <= '0;
        last_q   <= DIR_NONE;
      end else if (dir_i == last_q) begin
        if (streak_q < CNT_LIM) streak_q <= streak_q + 1'b1;
      end else begin
        streak_q <= CNT_W'(1);
        last_q   <= dir_i;
      end
    end
  end

  // R5: an idle accepted update leaves no streak behind
  a_r5_idle_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flush && dir_i == DIR_NONE) |=> (streak_q == '0));

  // R12: without the qualifier the streak does not move
  a_r12_streak_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !flush) |=> ($stable(streak_q) && $stable(last_q)));

endmodule

// File: rtl/bbpi_integrator.sv
module bbpi_integrator
  import bbpi_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int FRAC_W      = 8,
  parameter int KI_W        = 8,
  parameter int BOOST_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              adv,
  input  dir_t              dir,
  input  logic              boost,
  input  logic [KI_W-1:0]   ki,
  output logic [WORD_W-1:0] int_nx
);

  localparam int ACC_W = WORD_W + FRAC_W;
  localparam int SUM_W = ACC_W + 2;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0]        acc_q, acc_d, acc_sat;
  logic signed [SUM_W-1:0] step, sum;

  always_comb begin
    step = $signed({{(SUM_W-KI_W){1'b0}}, ki});
    if (boost) step = step <<< BOOST_SHIFT;
    sum = $signed({2'b00, acc_q});
    if (dir == DIR_UP)      sum = sum + step;
    else if (dir == DIR_DN) sum = sum - step;
    if (sum < 0)                               acc_sat = '0;
    else if (sum > $signed({2'b00, ACC_MAX}))  acc_sat = ACC_MAX;
    else                                       acc_sat = sum[ACC_W-1:0];
    if (load)     acc_d = {load_word, {FRAC_W{1'b0}}};
    else if (adv) acc_d = acc_sat;
    else          acc_d = acc_q;
  end

  assign int_nx = acc_d[ACC_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R11: full scale never wraps on a further upward step
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && acc_q == ACC_MAX && dir == DIR_UP) |=> (acc_q == ACC_MAX));

  // R11: zero never wraps on a further downward step
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && acc_q == '0 && dir == DIR_DN) |=> (acc_q == '0));

  // R12: integral state holds without the qualifier
  a_r12_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(acc_q));

endmodule

// File: rtl/bbpi_therm.sv
module bbpi_therm #(
  parameter int CODE_W = 8,
  parameter int LINES  = 255,
  parameter int INVERT = 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  lines
);

  localparam logic INV = (INVERT != 0);

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign lines[i] = INV ^ (code > CODE_W'(i));
    end
  endgenerate

endmodule

// File: rtl/bbpi_loop_filter.sv
module bbpi_loop_filter
  import bbpi_pkg::*;
#(
  parameter int WORD_W       = 10,
  parameter int CODE_W       = 8,
  parameter int FRAC_W       = 8,
  parameter int KI_W         = 8,
  parameter int KP_W         = 6,
  parameter int BOOST_SHIFT  = 0,
  parameter int BOOST_AFTER  = 4,
  parameter int FORCE_RAIL   = 0,
  parameter int THERM_INVERT = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic                          clr_i,
  input  logic                          ovr_i,
  input  logic                          upd_i,
  input  logic                          pol_i,
  input  logic [1:0]                    dec_i,
  input  logic [WORD_W-1:0]             ext_i,
  input  logic [KI_W-1:0]               ki_i,
  input  logic [KP_W-1:0]               kp_i,
  output logic [CODE_W-1:0]             code_o,
  output logic [(1 << CODE_W)-2:0]      therm_o
);

  localparam int LINES = (1 << CODE_W) - 1;
  localparam int DROP  = WORD_W - CODE_W;
  localparam int PS_W  = WORD_W + 2;
  localparam logic [WORD_W-1:0] WORD_MAX  = '1;
  localparam logic [LINES-1:0]  THERM_RST = (THERM_INVERT != 0) ? '1 : '0;

  logic              adv, upd_out;
  dir_t              dir_p, dir_i;
  logic              boost;
  logic [WORD_W-1:0] int_nx, word_cl, word_nx;
  logic [CODE_W-1:0] code_nx;
  logic [LINES-1:0]  therm_nx;
  logic signed [PS_W-1:0] psum, kp_s;

  assign adv     = en_i & ~clr_i & ~ovr_i & upd_i;
  assign upd_out = en_i | clr_i | ovr_i;

  bbpi_decision #(
    .CODE_W      (CODE_W),
    .BOOST_AFTER (BOOST_AFTER),
    .FORCE_RAIL  (FORCE_RAIL)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .flush (clr_i),
    .pol   (pol_i),
    .dec   (dec_i),
    .code  (code_o),
    .dir_p (dir_p),
    .dir_i (dir_i),
    .boost (boost)
  );

  bbpi_integrator #(
    .WORD_W      (WORD_W),
    .FRAC_W      (FRAC_W),
    .KI_W        (KI_W),
    .BOOST_SHIFT (BOOST_SHIFT)
  ) u_int (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (clr_i),
    .load_word (ext_i),
    .adv       (adv),
    .dir       (dir_i),
    .boost     (boost),
    .ki        (ki_i),
    .int_nx    (int_nx)
  );

  // Proportional term on the freshly updated integral word, clamped.
  always_comb begin
    kp_s = $signed({{(PS_W-KP_W){1'b0}}, kp_i});
    psum = $signed({2'b00, int_nx});
    if (dir_p == DIR_UP)      psum = psum + kp_s;
    else if (dir_p == DIR_DN) psum = psum - kp_s;
    if (psum < 0)                                 word_cl = '0;
    else if (psum > $signed({2'b00, WORD_MAX}))   word_cl = WORD_MAX;
    else                                          word_cl = psum[WORD_W-1:0];
    word_nx = (ovr_i | clr_i) ? ext_i : word_cl;
  end

  assign code_nx = word_nx[WORD_W-1:DROP];

  bbpi_therm #(
    .CODE_W (CODE_W),
    .LINES  (LINES),
    .INVERT (THERM_INVERT)
  ) u_therm (
    .code  (code_nx),
    .lines (therm_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o  <= '0;
      therm_o <= THERM_RST;
    end else if (upd_out) begin
      code_o  <= code_nx;
      therm_o <= therm_nx;
    end
  end

  // R7: enable low with no clear or override freezes both outputs
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i && !ovr_i) |=> ($stable(code_o) && $stable(therm_o)));

  // R7: clear drives the code from external data
  a_r7_clear_load: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_o == $past(ext_i[WORD_W-1:DROP])));

  // R8: override drives the code from external data
  a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_i |=> (code_o == $past(ext_i[WORD_W-1:DROP])));

  // R4: an outward decision at the low rail with kp of a full step leaves the rail
  a_r4_escape_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && !ovr_i && code_o == '0 &&
     (pol_i ? (dec_i == 2'b01) : (dec_i == 2'b10)) && kp_i >= KP_W'(4))
    |=> (code_o != '0));

  // R10: thermometer population always matches the registered code
  a_r10_therm_count: assert property (@(posedge clk) disable iff (!rst_n)
    int'($countones(therm_o)) ==
      ((THERM_INVERT != 0) ? (LINES - int'(code_o)) : int'(code_o)));

endmodule

// File: tb/bbpi_loop_filter_tb.sv
module bbpi_loop_filter_tb;

  localparam int BS = 2;   // boost shift under test
  localparam int BA = 3;   // boost after
  localparam int FR = 6;   // forced rail distance
  localparam int LINES = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, clr = 1'b0, ovr = 1'b0, upd = 1'b0, pol = 1'b1;
  logic [1:0] dec = 2'b00;
  logic [9:0] ext = '0;
  logic [7:0] ki = '0;
  logic [5:0] kp = '0;
  logic [7:0] code_o;
  logic [LINES-1:0] therm_o;

  int errors = 0;
  int checks = 0;

  // model state
  int m_acc = 0, m_streak = 0, m_last = 0, m_code = 0;

  always #2.5 clk = ~clk;

  bbpi_loop_filter #(
    .BOOST_SHIFT (BS),
    .BOOST_AFTER (BA),
    .FORCE_RAIL  (FR)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .en_i (en), .clr_i (clr), .ovr_i (ovr),
    .upd_i (upd), .pol_i (pol), .dec_i (dec), .ext_i (ext), .ki_i (ki),
    .kp_i (kp), .code_o (code_o), .therm_o (therm_o)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #500us;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [LINES-1:0] exp_therm(input int c);
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = (c <= i);
    return v;
  endfunction

  task automatic chk_therm(input string tag);
    logic [LINES-1:0] e;
    e = exp_therm(m_code);
    checks++;
    if (therm_o !== e) begin
      errors++;
      $display("FAIL %s therm: got %h expected %h", tag, therm_o, e);
    end
  endtask

  // Arithmetic model of the requirements, evaluated with pre-edge state.
  task automatic model_step();
    int raw, eff, esc, di, stp, nacc, w;
    bit adv, bst;
    raw = (dec == 2'b10) ? 1 : (dec == 2'b01) ? -1 : 0;
    eff = pol ? raw : -raw;
    esc = eff;
    if (m_code == 0 && eff < 0)   esc = 1;
    if (m_code == 255 && eff > 0) esc = -1;
    di = esc;
    if (m_code < FR)            di = 1;
    else if (m_code > 255 - FR) di = -1;
    adv = en && !clr && !ovr && upd;
    bst = (di != 0) && (di == m_last) && (m_streak >= BA);
    nacc = m_acc;
    if (clr) nacc = int'(ext) * 256;
    else if (adv) begin
      stp = bst ? (int'(ki) << BS) : int'(ki);
      nacc = m_acc + di * stp;
      if (nacc < 0) nacc = 0;
      if (nacc > 262143) nacc = 262143;
    end
    if (clr) begin
      m_streak = 0; m_last = 0;
    end else if (adv) begin
      if (di == 0) begin m_streak = 0; m_last = 0; end
      else if (di == m_last) begin if (m_streak < BA) m_streak++; end
      else begin m_streak = 1; m_last = di; end
    end
    if (ovr || clr) m_code = int'(ext) >> 2;
    else if (en) begin
      w = (nacc >> 8) + esc * int'(kp);
      if (w < 0) w = 0;
      if (w > 1023) w = 1023;
      m_code = w >> 2;
    end
    m_acc = nacc;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #1;
    chk(tag, int'(code_o), m_code);
    chk_therm(tag);
  endtask

  task automatic reload(input int word);
    en = 1'b0; ovr = 1'b0; clr = 1'b1; ext = 10'(word);
    tick("R7 reload");
    clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset code", int'(code_o), 0);
    checks++;
    if (therm_o !== '1) begin
      errors++;
      $display("FAIL R1 reset therm: got %h expected all ones", therm_o);
    end
    rst_n = 1'b1;

    // R10 thermometer sweep through override
    ovr = 1'b1;
    for (int c = 0; c < 256; c++) begin
      ext = 10'((c << 2) | (c & 3));
      tick("R10 R8 sweep");
    end
    ovr = 1'b0;

    // R7 clear and freeze
    reload(10'h155);
    chk("R7 clear code", int'(code_o), 8'h55);
    en = 1'b0; dec = 2'b10; kp = 6'd4; ki = 8'd255; upd = 1'b1;
    for (int k = 0; k < 3; k++) tick("R7 freeze");
    chk("R7 freeze code", int'(code_o), 8'h55);

    // R3 proportional, R9 polarity
    reload(512);
    en = 1'b1; upd = 1'b0; ki = 8'd0; kp = 6'd4; pol = 1'b1;
    dec = 2'b10; tick("R3 up");   chk("R3 up code", int'(code_o), 129);
    dec = 2'b01; tick("R3 down"); chk("R3 down code", int'(code_o), 127);
    dec = 2'b00; tick("R3 idle"); chk("R3 idle code", int'(code_o), 128);
    dec = 2'b11; tick("R3 idle11"); chk("R3 idle11 code", int'(code_o), 128);
    pol = 1'b0; dec = 2'b10; tick("R9 pol");
    chk("R9 reversed code", int'(code_o), 127);
    pol = 1'b1;

    // R12 qualifier low: integral does not move
    kp = 6'd0; ki = 8'd255; dec = 2'b10; upd = 1'b0;
    for (int k = 0; k < 10; k++) tick("R12 hold");
    chk("R12 hold code", int'(code_o), 128);

    // R2 fraction width: word 515 needs two full-gain steps
    reload(515);
    en = 1'b1; upd = 1'b1; ki = 8'd255; kp = 6'd0; dec = 2'b10;
    tick("R2 step1"); chk("R2 step1 code", int'(code_o), 128);
    tick("R2 step2"); chk("R2 step2 code", int'(code_o), 129);

    // R5 boost on the fourth same-direction update, restart on reversal
    reload(512);
    en = 1'b1; upd = 1'b1; ki = 8'd255; kp = 6'd0; dec = 2'b10;
    for (int k = 0; k < 3; k++) tick("R5 pre");
    chk("R5 pre code", int'(code_o), 128);
    tick("R5 boost"); chk("R5 boosted code", int'(code_o), 129);
    dec = 2'b01; tick("R5 reverse");
    dec = 2'b10; tick("R5 restart");
    chk("R5 restart code", int'(code_o), 129);

    // R4 rail escape
    reload(0);
    en = 1'b1; upd = 1'b0; ki = 8'd0; kp = 6'd4; dec = 2'b01;
    tick("R4 low"); chk("R4 low code", int'(code_o), 1);
    reload(1023);
    en = 1'b1; dec = 2'b10;
    tick("R4 high"); chk("R4 high code", int'(code_o), 254);

    // R11 clamp of proportional sum
    reload(1016);
    en = 1'b1; kp = 6'd63; dec = 2'b10;
    tick("R11 top"); chk("R11 top code", int'(code_o), 255);
    reload(8);
    en = 1'b1; dec = 2'b01;
    tick("R11 bottom"); chk("R11 bottom code", int'(code_o), 0);

    // R6 forced inward near the low rail despite a down decision
    reload(8);
    en = 1'b1; upd = 1'b1; ki = 8'd255; kp = 6'd0; dec = 2'b01;
    for (int k = 0; k < 4; k++) tick("R6 force");
    chk("R6 forced code", int'(code_o), 3);

    // R8 override leaves integrator untouched
    ovr = 1'b1; ext = 10'h2A7; tick("R8 ovr");
    chk("R8 ovr code", int'(code_o), 169);
    ovr = 1'b0; en = 1'b1; upd = 1'b0; dec = 2'b00;
    tick("R8 release");
    chk("R8 release code", int'(code_o), 3);

    // Mixed pseudo-random run against the model: R2 R3 R4 R5 R6 R7 R8 R9 R11 R12
    for (int n = 0; n < 3000; n++) begin
      int r, bias;
      r = int'($urandom);
      bias = (n / 300) % 3;
      clr = ((r % 61) == 0);
      ovr = ((r % 53) == 7);
      en  = (((r >> 6) & 7) != 0);
      upd = (((r >> 9) & 3) != 0);
      pol = (((r >> 11) & 15) != 0);
      if (bias == 0)      dec = (((r >> 15) & 7) != 0) ? 2'b10 : 2'(r >> 18);
      else if (bias == 1) dec = (((r >> 15) & 7) != 0) ? 2'b01 : 2'(r >> 18);
      else                dec = 2'(r >> 18);
      ki  = 8'($urandom);
      kp  = 6'($urandom);
      ext = 10'($urandom);
      tick("R2 R3 R5 random");
    end

    summary();
    $finish;
  end

endmodule